// File: doc/BRIEF.md
# Nibble-to-byte memory bridge

This block sits between a processor core that moves data one 4-bit nibble per handshake and a memory that stores 8-bit bytes. Each memory byte holds two neighbouring nibble addresses. The core opens a transfer by pulsing a start input with a nibble address, a nibble count and a direction. It then strobes once per nibble. The bridge turns that stream into byte reads and byte writes, and the number of memory accesses it uses depends on how the nibbles line up with byte boundaries.

An aligned pair of nibbles costs a single byte access. For a read, one captured byte serves both nibbles. For a write, the first nibble is held until its partner arrives, and the full byte is then written with no read before it. A nibble that has no partner in the same transfer needs more work. On a read it causes its own byte fetch. On a write the bridge reads the byte, replaces that one nibble, and writes the byte back. Whenever the memory has not yet answered, the bridge raises a wait output, so the core keeps its strobe asserted across several cycles.

Top module: `nib_byte_bridge`

## Requirements
- R1: The byte address driven to memory is the nibble address shifted right by one. With the default lane order, an even nibble address occupies byte bits 3:0 and an odd nibble address occupies bits 7:4.
- R2: A read that covers both nibbles of one byte, starting at an even nibble address, issues exactly one memory read and returns both nibbles from that byte.
- R3: A two-nibble read that starts at an odd nibble address touches two bytes and issues exactly two memory reads.
- R4: A write that supplies both nibbles of a byte, starting at an even nibble address, issues one memory write of the combined byte and no memory read.
- R5: A write that changes only one nibble of a byte (an odd first nibble, or an even last nibble) reads the byte, replaces that nibble, and writes the byte back to the same address. The other nibble keeps its old value.
- R6: While a memory access is outstanding, the core wait output stays high. The memory address, write data and read/write strobes stay unchanged until the cycle in which the memory ready input is high. This holds for any number of stall cycles.
- R7: A transfer of any length from 1 to 16 nibbles delivers its nibbles in ascending address order. Reads equal the number of bytes touched. Writes equal the bytes touched. Reads during a write transfer equal the bytes that are only partly covered.
- R8: A byte captured during one read transfer is never reused by a later transfer. Two one-nibble reads of the same byte in separate transfers cost two memory reads.
- R9: A start pulse is ignored while a transfer is in progress, and a start with a length of zero opens no transfer and makes no memory access.
- R10: After reset, busy, wait, the memory read strobe and the memory write strobe are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| xfer_start | input | 1 | Pulse that opens a transfer |
| xfer_addr | input | NA_W | First nibble address of the transfer |
| xfer_len | input | LEN_W | Number of nibbles in the transfer; zero means no transfer |
| xfer_write | input | 1 | 1 for a write transfer, 0 for a read transfer |
| xfer_busy | output | 1 | High from start until the last memory access completes |
| nib_stb | input | 1 | Core nibble strobe; a nibble moves in a cycle where it is high and wait is low |
| nib_wdata | input | NIB_W | Nibble written by the core |
| nib_rdata | output | NIB_W | Nibble returned to the core, valid while strobe is high and wait is low |
| nib_wait | output | 1 | Holds the core strobe while memory is pending |
| mem_addr | output | NA_W-1 | Byte address to memory |
| mem_rd | output | 1 | Byte read request |
| mem_wr | output | 1 | Byte write request |
| mem_wdata | output | 2*NIB_W | Byte written to memory |
| mem_rdata | input | 2*NIB_W | Byte read from memory |
| mem_ready | input | 1 | Memory completes the pending access in this cycle |

## Verification
A nibble's read data is due in the first cycle where the strobe is high and wait is low. That is one cycle after the memory accepts a read on a miss, or the same cycle on a hit. The bench raises the strobe at a falling edge, polls wait only at falling edges, and samples read data at the falling edge where wait is first seen low. Memory access counts are taken at rising edges where a request meets ready. Written bytes and busy are checked only after busy has been seen low at a falling edge. The ready input is programmed to stall for a fixed number of cycles, and the number of cycles the strobe was held is then compared with that stall.

// File: rtl/nbb_pkg.sv
package nbb_pkg;
   typedef enum logic [2:0] {
      NBB_IDLE   = 3'd0,
      NBB_ACT    = 3'd1,
      NBB_RD     = 3'd2,
      NBB_RMW_RD = 3'd3,
      NBB_WR     = 3'd4
   } nbb_state_e;
endpackage

// File: rtl/nbb_lane_sel.sv
module nbb_lane_sel #(
   parameter int NIB_W    = 4,
   parameter bit ODD_HIGH = 1'b1
) (
   input  logic [2*NIB_W-1:0] byte_i,
   input  logic               odd_i,
   output logic [NIB_W-1:0]   nib_o
);
   localparam int BYTE_W = 2 * NIB_W;

   logic [NIB_W-1:0] hi_nib;
   logic [NIB_W-1:0] lo_nib;
   assign hi_nib = byte_i[BYTE_W-1:NIB_W];
   assign lo_nib = byte_i[NIB_W-1:0];

   generate
      if (ODD_HIGH) begin : g_odd_hi
         assign nib_o = odd_i ? hi_nib : lo_nib;
      end else begin : g_odd_lo
         assign nib_o = odd_i ? lo_nib : hi_nib;
      end
   endgenerate
endmodule

// File: rtl/nbb_lane_ins.sv
module nbb_lane_ins #(
   parameter int NIB_W    = 4,
   parameter bit ODD_HIGH = 1'b1
) (
   input  logic [2*NIB_W-1:0] base_i,
   input  logic               odd_i,
   input  logic [NIB_W-1:0]   nib_i,
   output logic [2*NIB_W-1:0] byte_o
);
   localparam int BYTE_W = 2 * NIB_W;

   logic put_high;

   generate
      if (ODD_HIGH) begin : g_odd_hi
         assign put_high = odd_i;
      end else begin : g_odd_lo
         assign put_high = ~odd_i;
      end
   endgenerate

   assign byte_o = put_high ? {nib_i, base_i[NIB_W-1:0]}
                            : {base_i[BYTE_W-1:NIB_W], nib_i};
endmodule

// File: rtl/nib_byte_bridge.sv
module nib_byte_bridge
   import nbb_pkg::*;
#(
   parameter int NA_W     = 8,
   parameter int LEN_W    = 5,
   parameter int NIB_W    = 4,
   parameter bit ODD_HIGH = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 xfer_start,
   input  logic [NA_W-1:0]      xfer_addr,
   input  logic [LEN_W-1:0]     xfer_len,
   input  logic                 xfer_write,
   output logic                 xfer_busy,
   input  logic                 nib_stb,
   input  logic [NIB_W-1:0]     nib_wdata,
   output logic [NIB_W-1:0]     nib_rdata,
   output logic                 nib_wait,
   output logic [NA_W-2:0]      mem_addr,
   output logic                 mem_rd,
   output logic                 mem_wr,
   output logic [2*NIB_W-1:0]   mem_wdata,
   input  logic [2*NIB_W-1:0]   mem_rdata,
   input  logic                 mem_ready
);
   localparam int BA_W   = NA_W - 1;
   localparam int BYTE_W = 2 * NIB_W;

   generate
      if (NA_W < 2) begin : g_bad_na
         $error("nib_byte_bridge: NA_W must be at least 2");
      end
      if (LEN_W < 1) begin : g_bad_len
         $error("nib_byte_bridge: LEN_W must be at least 1");
      end
      if (NIB_W < 1) begin : g_bad_nib
         $error("nib_byte_bridge: NIB_W must be at least 1");
      end
   endgenerate

   nbb_state_e          state_q;
   logic [NA_W-1:0]     cur_q;
   logic [LEN_W-1:0]    rem_q;
   logic                dir_wr_q;
   logic [BYTE_W-1:0]   cache_q;
   logic [BA_W-1:0]     tag_q;
   logic                cache_ok_q;
   logic [BYTE_W-1:0]   wbyte_q;
   logic                hold_q;
   logic [NIB_W-1:0]    pnib_q;
   logic                plane_q;
   logic [BA_W-1:0]     maddr_q;
   logic                mrd_q;
   logic                mwr_q;
   logic [BYTE_W-1:0]   mwdata_q;

   logic                hit;
   logic                last;
   logic                accept;
   logic [BYTE_W-1:0]   core_ins;
   logic [BYTE_W-1:0]   rmw_ins;

   assign hit    = cache_ok_q && (tag_q == cur_q[NA_W-1:1]);
   assign last   = (rem_q == LEN_W'(1));
   assign nib_wait = (state_q != NBB_IDLE) &&
                     !((state_q == NBB_ACT) && (dir_wr_q || hit));
   assign accept = (state_q == NBB_ACT) && nib_stb && !nib_wait;

   assign xfer_busy = (state_q != NBB_IDLE);
   assign mem_addr  = maddr_q;
   assign mem_rd    = mrd_q;
   assign mem_wr    = mwr_q;
   assign mem_wdata = mwdata_q;

   nbb_lane_sel #(.NIB_W(NIB_W), .ODD_HIGH(ODD_HIGH)) u_rsel (
      .byte_i (cache_q),
      .odd_i  (cur_q[0]),
      .nib_o  (nib_rdata)
   );

   nbb_lane_ins #(.NIB_W(NIB_W), .ODD_HIGH(ODD_HIGH)) u_cins (
      .base_i (wbyte_q),
      .odd_i  (cur_q[0]),
      .nib_i  (nib_wdata),
      .byte_o (core_ins)
   );

   nbb_lane_ins #(.NIB_W(NIB_W), .ODD_HIGH(ODD_HIGH)) u_mins (
      .base_i (mem_rdata),
      .odd_i  (plane_q),
      .nib_i  (pnib_q),
      .byte_o (rmw_ins)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= NBB_IDLE;
         cur_q      <= '0;
         rem_q      <= '0;
         dir_wr_q   <= 1'b0;
         cache_q    <= '0;
         tag_q      <= '0;
         cache_ok_q <= 1'b0;
         wbyte_q    <= '0;
         hold_q     <= 1'b0;
         pnib_q     <= '0;
         plane_q    <= 1'b0;
         maddr_q    <= '0;
         mrd_q      <= 1'b0;
         mwr_q      <= 1'b0;
         mwdata_q   <= '0;
      end else begin
         unique case (state_q)
            NBB_IDLE: begin
               if (xfer_start && (xfer_len != '0)) begin
                  cur_q      <= xfer_addr;
                  rem_q      <= xfer_len;
                  dir_wr_q   <= xfer_write;
                  cache_ok_q <= 1'b0;
                  hold_q     <= 1'b0;
                  state_q    <= NBB_ACT;
               end
            end
            NBB_ACT: begin
               if (!dir_wr_q) begin
                  if (accept) begin
                     cur_q <= cur_q + NA_W'(1);
                     rem_q <= rem_q - LEN_W'(1);
                     if (last) begin
                        cache_ok_q <= 1'b0;
                        state_q    <= NBB_IDLE;
                     end
                  end else if (nib_stb) begin
                     maddr_q <= cur_q[NA_W-1:1];
                     mrd_q   <= 1'b1;
                     state_q <= NBB_RD;
                  end
               end else if (accept) begin
                  cur_q <= cur_q + NA_W'(1);
                  rem_q <= rem_q - LEN_W'(1);
                  if (!cur_q[0] && !last) begin
                     wbyte_q <= core_ins;
                     hold_q  <= 1'b1;
                  end else if (cur_q[0] && hold_q) begin
                     mwdata_q <= core_ins;
                     maddr_q  <= cur_q[NA_W-1:1];
                     mwr_q    <= 1'b1;
                     hold_q   <= 1'b0;
                     state_q  <= NBB_WR;
                  end else begin
                     pnib_q  <= nib_wdata;
                     plane_q <= cur_q[0];
                     maddr_q <= cur_q[NA_W-1:1];
                     mrd_q   <= 1'b1;
                     state_q <= NBB_RMW_RD;
                  end
               end
            end
            NBB_RD: begin
               if (mem_ready) begin
                  cache_q    <= mem_rdata;
                  tag_q      <= maddr_q;
                  cache_ok_q <= 1'b1;
                  mrd_q      <= 1'b0;
                  state_q    <= NBB_ACT;
               end
            end
            NBB_RMW_RD: begin
               if (mem_ready) begin
                  mwdata_q <= rmw_ins;
                  mrd_q    <= 1'b0;
                  mwr_q    <= 1'b1;
                  state_q  <= NBB_WR;
               end
            end
            NBB_WR: begin
               if (mem_ready) begin
                  mwr_q   <= 1'b0;
                  state_q <= (rem_q == '0) ? NBB_IDLE : NBB_ACT;
               end
            end
            default: state_q <= NBB_IDLE;
         endcase
      end
   end

   AST_RD_ADDR_MAP: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd && (state_q == NBB_RD)) |-> (mem_addr == cur_q[NA_W-1:1])); // R1

   AST_HIT_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == NBB_ACT) && !dir_wr_q && nib_stb && hit) |=> !mem_rd); // R2

   AST_MISS_FETCHES: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == NBB_ACT) && !dir_wr_q && nib_stb && !hit) |=> mem_rd); // R3

   AST_FULL_WR_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && dir_wr_q && cur_q[0] && hold_q) |=> (mem_wr && !mem_rd)); // R4

   AST_RMW_SAME_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == NBB_RMW_RD) && mem_ready) |=> (mem_wr && $stable(mem_addr))); // R5

   AST_HOLD_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      ((mem_rd || mem_wr) && !mem_ready) |=>
         ($stable(mem_addr) && $stable(mem_wdata) && $stable(mem_rd) && $stable(mem_wr))); // R6

   AST_WAIT_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd || mem_wr) |-> nib_wait); // R6

   AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr)); // R6

   AST_ADDR_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !last) |=> (cur_q == $past(cur_q) + NA_W'(1))); // R7

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !xfer_busy |-> (!mem_rd && !mem_wr && !nib_wait)); // R10
endmodule

// File: tb/nib_byte_bridge_bench.sv
module nib_byte_bridge_bench;
   localparam int NA_W   = 8;
   localparam int LEN_W  = 5;
   localparam int NIB_W  = 4;
   localparam int NBYTES = 1 << (NA_W - 1);
   localparam int NNIBS  = 1 << NA_W;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             xfer_start = 1'b0;
   logic [NA_W-1:0]  xfer_addr = '0;
   logic [LEN_W-1:0] xfer_len = '0;
   logic             xfer_write = 1'b0;
   logic             xfer_busy;
   logic             nib_stb = 1'b0;
   logic [3:0]       nib_wdata = '0;
   logic [3:0]       nib_rdata;
   logic             nib_wait;
   logic [NA_W-2:0]  mem_addr;
   logic             mem_rd;
   logic             mem_wr;
   logic [7:0]       mem_wdata;
   logic [7:0]       mem_rdata;
   logic             mem_ready = 1'b0;

   logic [7:0] mem_m  [NBYTES];
   logic [3:0] shadow [NNIBS];

   int checks = 0;
   int fails = 0;
   int rd_cnt = 0;
   int wr_cnt = 0;
   int mem_delay = 0;
   int dly_cnt = 0;
   bit served = 1'b0;

   always #4 clk = ~clk;

   nib_byte_bridge #(.NA_W(NA_W), .LEN_W(LEN_W), .NIB_W(NIB_W)) u_nib_byte_bridge (
      .clk(clk), .rst_n(rst_n),
      .xfer_start(xfer_start), .xfer_addr(xfer_addr), .xfer_len(xfer_len),
      .xfer_write(xfer_write), .xfer_busy(xfer_busy),
      .nib_stb(nib_stb), .nib_wdata(nib_wdata), .nib_rdata(nib_rdata), .nib_wait(nib_wait),
      .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready)
   );

   assign mem_rdata = mem_m[mem_addr];

   always @(posedge clk) begin
      if (mem_ready && (mem_rd || mem_wr)) begin
         if (mem_rd) rd_cnt++;
         if (mem_wr) begin
            wr_cnt++;
            mem_m[mem_addr] <= mem_wdata;
         end
         served = 1'b1;
      end
   end

   always @(negedge clk) begin
      if (served) begin
         dly_cnt = 0;
         served = 1'b0;
      end
      if (mem_rd || mem_wr) begin
         if (dly_cnt >= mem_delay) mem_ready = 1'b1;
         else begin
            mem_ready = 1'b0;
            dly_cnt++;
         end
      end else begin
         mem_ready = 1'b0;
         dly_cnt = 0;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic clear_counts();
      rd_cnt = 0;
      wr_cnt = 0;
   endtask

   task automatic start_xfer(input int a, input int n, input bit w);
      xfer_addr  = a[NA_W-1:0];
      xfer_len   = n[LEN_W-1:0];
      xfer_write = w;
      xfer_start = 1'b1;
      @(negedge clk);
      xfer_start = 1'b0;
   endtask

   task automatic read_nib(output logic [3:0] v, output int waits);
      nib_stb = 1'b1;
      #1;
      waits = 0;
      while (nib_wait) begin
         @(negedge clk);
         waits++;
      end
      v = nib_rdata;
      @(negedge clk);
      nib_stb = 1'b0;
   endtask

   task automatic write_nib(input logic [3:0] d, output int waits);
      nib_wdata = d;
      nib_stb = 1'b1;
      #1;
      waits = 0;
      while (nib_wait) begin
         @(negedge clk);
         waits++;
      end
      @(negedge clk);
      nib_stb = 1'b0;
   endtask

   task automatic wait_idle();
      while (xfer_busy) @(negedge clk);
   endtask

   task automatic read_run(input int a, input int n, input string req, output int max_wait);
      logic [3:0] v;
      int w;
      max_wait = 0;
      start_xfer(a, n, 1'b0);
      for (int i = 0; i < n; i++) begin
         read_nib(v, w);
         if (w > max_wait) max_wait = w;
         check(v == shadow[(a + i) % NNIBS], req, v, shadow[(a + i) % NNIBS]);
      end
      wait_idle();
   endtask

   task automatic write_run(input int a, input int n, input int seed);
      logic [3:0] d;
      int w;
      start_xfer(a, n, 1'b1);
      for (int i = 0; i < n; i++) begin
         d = 4'((seed + i * 5) & 15);
         write_nib(d, w);
         shadow[(a + i) % NNIBS] = d;
      end
      wait_idle();
   endtask

   task automatic check_byte(input int b, input string req);
      logic [7:0] exp;
      exp = {shadow[2 * b + 1], shadow[2 * b]};
      check(mem_m[b] == exp, req, mem_m[b], exp);
   endtask

   task automatic t_reset();
      check(!xfer_busy, "R10 busy", xfer_busy, 0);
      check(!mem_rd && !mem_wr, "R10 strobes", {mem_rd, mem_wr}, 0);
      check(!nib_wait, "R10 wait", nib_wait, 0);
   endtask

   task automatic t_aligned_read();
      int mw;
      clear_counts();
      read_run(6, 2, "R2 data", mw);
      check(rd_cnt == 1, "R2 reads", rd_cnt, 1);
      check(wr_cnt == 0, "R2 writes", wr_cnt, 0);
   endtask

   task automatic t_odd_read();
      int mw;
      clear_counts();
      read_run(9, 2, "R3 data", mw);
      check(rd_cnt == 2, "R3 reads", rd_cnt, 2);
   endtask

   task automatic t_full_write();
      clear_counts();
      write_run(20, 2, 3);
      check(wr_cnt == 1, "R4 writes", wr_cnt, 1);
      check(rd_cnt == 0, "R4 reads", rd_cnt, 0);
      // R1: nibble 20 lands in bits 3:0 and nibble 21 in bits 7:4 of byte 10
      check(mem_m[10] == {4'((3 + 5) & 15), 4'd3}, "R1 lanes", mem_m[10], {4'd8, 4'd3});
   endtask

   task automatic t_partial_write();
      logic [3:0] keep;
      clear_counts();
      keep = mem_m[15][3:0];
      write_run(31, 1, 9);
      check(rd_cnt == 1 && wr_cnt == 1, "R5 odd lone counts", rd_cnt * 16 + wr_cnt, 17);
      check(mem_m[15] == {4'd9, keep}, "R5 odd lone byte", mem_m[15], {4'd9, keep});
      clear_counts();
      write_run(40, 3, 1);
      check(rd_cnt == 1 && wr_cnt == 2, "R5 even tail counts", rd_cnt * 16 + wr_cnt, 18);
      check_byte(20, "R5 full byte");
      check_byte(21, "R5 even tail byte");
   endtask

   task automatic t_stall();
      int mw;
      mem_delay = 4;
      clear_counts();
      read_run(3, 3, "R6 stall data", mw);
      check(mw >= 4, "R6 wait held", mw, 4);
      check(rd_cnt == 2, "R6 stall reads", rd_cnt, 2);
      clear_counts();
      write_run(45, 2, 6);
      check(rd_cnt == 2 && wr_cnt == 2, "R6 stall rmw counts", rd_cnt * 16 + wr_cnt, 34);
      check_byte(22, "R6 stall byte lo");
      check_byte(23, "R6 stall byte hi");
      mem_delay = 0;
   endtask

   task automatic t_lengths();
      int mw;
      clear_counts();
      write_run(65, 16, 2);
      check(wr_cnt == 9, "R7 len16 writes", wr_cnt, 9);
      check(rd_cnt == 2, "R7 len16 rmw reads", rd_cnt, 2);
      for (int b = 32; b <= 40; b++) check_byte(b, "R7 len16 bytes");
      clear_counts();
      read_run(65, 16, "R7 len16 order", mw);
      check(rd_cnt == 9, "R7 len16 reads", rd_cnt, 9);
      clear_counts();
      read_run(0, 1, "R7 len1 data", mw);
      check(rd_cnt == 1, "R7 len1 reads", rd_cnt, 1);
   endtask

   task automatic t_no_reuse();
      int mw;
      clear_counts();
      read_run(50, 1, "R8 first", mw);
      read_run(51, 1, "R8 second", mw);
      check(rd_cnt == 2, "R8 reads", rd_cnt, 2);
   endtask

   task automatic t_start_ignored();
      logic [3:0] v;
      int w;
      clear_counts();
      start_xfer(12, 2, 1'b0);
      start_xfer(100, 5, 1'b1);
      read_nib(v, w);
      check(v == shadow[12], "R9 busy start nib0", v, shadow[12]);
      read_nib(v, w);
      check(v == shadow[13], "R9 busy start nib1", v, shadow[13]);
      wait_idle();
      check(rd_cnt == 1 && wr_cnt == 0, "R9 busy start counts", rd_cnt * 16 + wr_cnt, 16);
      clear_counts();
      start_xfer(30, 0, 1'b1);
      repeat (3) @(negedge clk);
      check(!xfer_busy, "R9 zero length busy", xfer_busy, 0);
      check(rd_cnt == 0 && wr_cnt == 0, "R9 zero length counts", rd_cnt * 16 + wr_cnt, 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      for (int i = 0; i < NBYTES; i++) begin
         mem_m[i] = 8'((i * 37 + 11) & 255);
         shadow[2 * i]     = mem_m[i][3:0];
         shadow[2 * i + 1] = mem_m[i][7:4];
      end
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_aligned_read();
      t_odd_read();
      t_full_write();
      t_partial_write();
      t_stall();
      t_lengths();
      t_no_reuse();
      t_start_ignored();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule